// File: doc/BRIEF.md
# Application register bank with soft reset

This block is a small memory-mapped register bank that sits on a 32-bit target bus with a write enable for each byte. It decodes a 4 KB window and stores two video front-end configuration words, a system control word and a guest-bus timing word. It also answers a fixed status read. Writes land on the rising clock edge. Reads are combinational from the stored state, so the read data follows the address in the same cycle.

The system control word carries a soft-reset flag in its top byte. When a write enables that byte and carries a 0 in the flag position, every other register returns to its default value, and the rest of that write is dropped. When the flag is written as 1, normal writes continue. A hardware reset clears the flag and applies the same defaults.

The guest-bus read word packs a fixed identification byte above four timing nibbles. Offsets that map to no register read as zero and ignore writes.

Top module: `appreg_bank`

## Requirements
- R1: The bank decodes byte address bits 11:2 as a word index. Offset 0x000 holds the horizontal config, 0x004 the vertical config, 0x028 the control word, 0x02C the guest-bus word and 0x044 the status word. Address bits 1:0 do not affect decode.
- R2: After hardware reset, both config words read 0x000007FF (bits 19:10 = 0x001, bits 9:0 = 0x3FF, bit 30 = 0). The control word reads 0x000000FF and the guest-bus word reads 0x7E000000.
- R3: For a write to a config word, each enabled byte lane replaces its byte and each disabled lane keeps its old byte. The word reads back exactly as stored.
- R4: A write to 0x028 with lane 3 enabled stores wr_data bit 24 as the soft-reset flag. If that bit is 0, both config words, the wait-state field, the GPIO direction (set to 0xFF) and all timing nibbles return to defaults in the same edge, and the remaining lanes of that write are discarded.
- R5: In the control word, the wait-state field (bits 18:16) updates only when lane 2 is enabled and the GPIO direction (bits 7:0) updates only when lane 0 is enabled. A read returns the flag at bit 24, the wait-state at 18:16 and the direction at 7:0, with all other bits 0.
- R6: The guest-bus timing nibbles sit at bits 15:12, 11:8, 7:4 and 3:0. Lane 1 updates the upper two nibbles and lane 0 updates the lower two. Lanes 2 and 3 have no effect on this word.
- R7: A read of 0x02C returns 0x7E in bits 31:24 and zero in bits 23:16.
- R8: A read of 0x044 always returns 0x00000003, and writes there change nothing.
- R9: Reads of any other offset in the window return zero, and writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 12 | Byte address within the window |
| byte_en | input | 4 | Byte-lane write enables, lane n covers bits 8n+7:8n |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |

## Verification
On every cycle, the assertions check the following:
- After a soft-reset write, every register holds its default.
- A register that was not addressed, or whose lane was disabled, holds its value.
- The identification byte, the status word and the zero read of unmapped offsets appear on rd_data whenever they are addressed.

Only the bench scenarios can show the rest:
- The exact byte merge for all sixteen lane patterns.
- That the remaining lanes of a soft-reset write are dropped.
- That writes to unmapped offsets leave every mapped register unchanged, checked by reading back the full window.

// File: rtl/appreg_pkg.sv
package appreg_pkg;
   localparam int unsigned BUS_W    = 32;
   localparam int unsigned N_LANES  = BUS_W / 8;
   // word indices (byte offset / 4); the bus master depends on these
   localparam int unsigned WIX_HCFG  = 0;
   localparam int unsigned WIX_VCFG  = 1;
   localparam int unsigned WIX_CTRL  = 10;
   localparam int unsigned WIX_GUEST = 11;
   localparam int unsigned WIX_STAT  = 17;
   // control word field positions
   localparam int unsigned CTRL_FLAG_BIT = 24;
   localparam int unsigned CTRL_WAIT_LSB = 16;
   localparam int unsigned CTRL_GPIO_LSB = 0;
endpackage

// File: rtl/appreg_cfg_word.sv
module appreg_cfg_word #(
   parameter int unsigned          W       = 32,
   parameter logic [W-1:0]         DEFAULT = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           soft_rst,
   input  logic           wr_hit,
   input  logic [W/8-1:0] byte_en,
   input  logic [W-1:0]   wr_data,
   output logic [W-1:0]   q
);
   localparam int unsigned NL = W / 8;

   if (W % 8 != 0) begin : g_bad_w
      $error("appreg_cfg_word: W must be a whole number of bytes");
   end

   for (genvar l = 0; l < NL; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[l*8 +: 8] <= DEFAULT[l*8 +: 8];
         end else if (soft_rst) begin
            q[l*8 +: 8] <= DEFAULT[l*8 +: 8];
         end else if (wr_hit && byte_en[l]) begin
            q[l*8 +: 8] <= wr_data[l*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/appreg_sysctl.sv
module appreg_sysctl
   import appreg_pkg::*;
#(
   parameter int unsigned WAIT_W = 3,
   parameter int unsigned GPIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [3:0]        byte_en,
   input  logic [31:0]       wr_data,
   output logic              soft_rst,
   output logic              flag_q,
   output logic [WAIT_W-1:0] wait_q,
   output logic [GPIO_W-1:0] gpio_q
);
   if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_wait
      $error("appreg_sysctl: WAIT_W must be 1..8");
   end
   if (GPIO_W < 1 || GPIO_W > 8) begin : g_bad_gpio
      $error("appreg_sysctl: GPIO_W must be 1..8");
   end

   logic flag_lane;
   assign flag_lane = wr_hit && byte_en[3];
   assign soft_rst  = flag_lane && !wr_data[CTRL_FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         wait_q <= '0;
         gpio_q <= '1;
      end else begin
         if (flag_lane) flag_q <= wr_data[CTRL_FLAG_BIT];
         if (soft_rst) begin
            wait_q <= '0;
            gpio_q <= '1;
         end else if (wr_hit) begin
            if (byte_en[2]) wait_q <= wr_data[CTRL_WAIT_LSB +: WAIT_W];
            if (byte_en[0]) gpio_q <= wr_data[CTRL_GPIO_LSB +: GPIO_W];
         end
      end
   end
endmodule

// File: rtl/appreg_guest_timing.sv
module appreg_guest_timing #(
   parameter int unsigned N_FIELDS = 4,
   parameter int unsigned FIELD_W  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        soft_rst,
   input  logic                        wr_hit,
   input  logic [3:0]                  byte_en,
   input  logic [31:0]                 wr_data,
   output logic [N_FIELDS*FIELD_W-1:0] tim_q
);
   localparam int unsigned TOT_W = N_FIELDS * FIELD_W;

   if (TOT_W > 16) begin : g_bad_tot
      $error("appreg_guest_timing: timing fields must fit in lanes 0 and 1");
   end
   if (8 % FIELD_W != 0) begin : g_bad_fw
      $error("appreg_guest_timing: FIELD_W must divide a byte");
   end

   for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
      localparam int unsigned LANE = (i * FIELD_W) / 8;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tim_q[i*FIELD_W +: FIELD_W] <= '0;
         end else if (soft_rst) begin
            tim_q[i*FIELD_W +: FIELD_W] <= '0;
         end else if (wr_hit && byte_en[LANE]) begin
            tim_q[i*FIELD_W +: FIELD_W] <= wr_data[i*FIELD_W +: FIELD_W];
         end
      end
   end
endmodule

// File: rtl/appreg_bank.sv
module appreg_bank
   import appreg_pkg::*;
#(
   parameter int unsigned  ADDR_W    = 12,
   parameter logic [31:0]  CFG_DEF   = 32'h0000_07FF,
   parameter int unsigned  WAIT_W    = 3,
   parameter int unsigned  GPIO_W    = 8,
   parameter int unsigned  N_TFIELD  = 4,
   parameter int unsigned  TFIELD_W  = 4,
   parameter logic [7:0]   ID_BYTE   = 8'h7E,
   parameter logic [31:0]  STAT_VAL  = 32'h0000_0003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        byte_en,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data
);
   localparam int unsigned WIX_W = ADDR_W - 2;
   localparam int unsigned TIM_W = N_TFIELD * TFIELD_W;
   localparam logic [WIX_W-1:0] IX_HCFG  = WIX_W'(WIX_HCFG);
   localparam logic [WIX_W-1:0] IX_VCFG  = WIX_W'(WIX_VCFG);
   localparam logic [WIX_W-1:0] IX_CTRL  = WIX_W'(WIX_CTRL);
   localparam logic [WIX_W-1:0] IX_GUEST = WIX_W'(WIX_GUEST);
   localparam logic [WIX_W-1:0] IX_STAT  = WIX_W'(WIX_STAT);

   if (ADDR_W < 7) begin : g_bad_addr
      $error("appreg_bank: ADDR_W too small to reach the status word");
   end

   logic [WIX_W-1:0]  word_ix;
   logic              hit_h, hit_v, hit_c, hit_g;
   logic              soft_rst;
   logic [31:0]       hcfg_q, vcfg_q;
   logic              flag_q;
   logic [WAIT_W-1:0] wait_q;
   logic [GPIO_W-1:0] gpio_q;
   logic [TIM_W-1:0]  tim_q;

   assign word_ix = addr[ADDR_W-1:2];
   assign hit_h   = wr_en && (word_ix == IX_HCFG);
   assign hit_v   = wr_en && (word_ix == IX_VCFG);
   assign hit_c   = wr_en && (word_ix == IX_CTRL);
   assign hit_g   = wr_en && (word_ix == IX_GUEST);

   appreg_cfg_word #(.W(32), .DEFAULT(CFG_DEF)) u_hcfg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_hit(hit_h),
      .byte_en(byte_en), .wr_data(wr_data), .q(hcfg_q));

   appreg_cfg_word #(.W(32), .DEFAULT(CFG_DEF)) u_vcfg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_hit(hit_v),
      .byte_en(byte_en), .wr_data(wr_data), .q(vcfg_q));

   appreg_sysctl #(.WAIT_W(WAIT_W), .GPIO_W(GPIO_W)) u_sysctl (
      .clk(clk), .rst_n(rst_n), .wr_hit(hit_c), .byte_en(byte_en),
      .wr_data(wr_data), .soft_rst(soft_rst), .flag_q(flag_q),
      .wait_q(wait_q), .gpio_q(gpio_q));

   appreg_guest_timing #(.N_FIELDS(N_TFIELD), .FIELD_W(TFIELD_W)) u_guest (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_hit(hit_g),
      .byte_en(byte_en), .wr_data(wr_data), .tim_q(tim_q));

   always_comb begin
      rd_data = '0;
      case (word_ix)
         IX_HCFG:  rd_data = hcfg_q;
         IX_VCFG:  rd_data = vcfg_q;
         IX_CTRL: begin
            rd_data[CTRL_FLAG_BIT]             = flag_q;
            rd_data[CTRL_WAIT_LSB +: WAIT_W]   = wait_q;
            rd_data[CTRL_GPIO_LSB +: GPIO_W]   = gpio_q;
         end
         IX_GUEST: begin
            rd_data[31:24]     = ID_BYTE;
            rd_data[TIM_W-1:0] = tim_q;
         end
         IX_STAT:  rd_data = STAT_VAL;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/appreg_bank_chk.sv
module appreg_bank_chk #(
   parameter int unsigned ADDR_W   = 12,
   parameter logic [31:0] CFG_DEF  = 32'h0000_07FF,
   parameter int unsigned WAIT_W   = 3,
   parameter int unsigned GPIO_W   = 8,
   parameter int unsigned TIM_W    = 16,
   parameter logic [7:0]  ID_BYTE  = 8'h7E,
   parameter logic [31:0] STAT_VAL = 32'h0000_0003
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [3:0]        byte_en,
   input logic [31:0]       wr_data,
   input logic [31:0]       rd_data,
   input logic [31:0]       hcfg_q,
   input logic [31:0]       vcfg_q,
   input logic              flag_q,
   input logic [WAIT_W-1:0] wait_q,
   input logic [GPIO_W-1:0] gpio_q,
   input logic [TIM_W-1:0]  tim_q
);
   localparam int unsigned WIX_W = ADDR_W - 2;
   logic [WIX_W-1:0] ix;
   logic             sr_req, to_h, to_c, to_g, mapped;
   assign ix     = addr[ADDR_W-1:2];
   assign to_h   = wr_en && ix == WIX_W'(0);
   assign to_c   = wr_en && ix == WIX_W'(10);
   assign to_g   = wr_en && ix == WIX_W'(11);
   assign sr_req = to_c && byte_en[3] && !wr_data[24];
   assign mapped = ix == WIX_W'(0) || ix == WIX_W'(1) || ix == WIX_W'(10) ||
                   ix == WIX_W'(11) || ix == WIX_W'(17);

   AST_SOFT_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      sr_req |=> (hcfg_q == CFG_DEF && vcfg_q == CFG_DEF && !flag_q &&
                  wait_q == '0 && gpio_q == '1 && tim_q == '0)); // R4
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!to_h && !sr_req) |=> $stable(hcfg_q)); // R3
   AST_WAIT_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(to_c && byte_en[2]) && !sr_req) |=> $stable(wait_q)); // R5
   AST_GPIO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(to_c && byte_en[0]) && !sr_req) |=> $stable(gpio_q)); // R5
   AST_TIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(to_g && (byte_en[0] || byte_en[1])) && !sr_req) |=> $stable(tim_q)); // R6
   AST_ID_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (ix == WIX_W'(11)) |-> (rd_data[31:16] == {ID_BYTE, 8'h00})); // R7
   AST_STATUS_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      (ix == WIX_W'(17)) |-> (rd_data == STAT_VAL)); // R8
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (rd_data == 32'h0)); // R9
endmodule

bind appreg_bank appreg_bank_chk #(
   .ADDR_W(ADDR_W), .CFG_DEF(CFG_DEF), .WAIT_W(WAIT_W), .GPIO_W(GPIO_W),
   .TIM_W(N_TFIELD*TFIELD_W), .ID_BYTE(ID_BYTE), .STAT_VAL(STAT_VAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .byte_en(byte_en),
   .wr_data(wr_data), .rd_data(rd_data), .hcfg_q(hcfg_q), .vcfg_q(vcfg_q),
   .flag_q(flag_q), .wait_q(wait_q), .gpio_q(gpio_q), .tim_q(tim_q));

// File: tb/sim_appreg_bank.sv
`timescale 1ns/1ps
module sim_appreg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [3:0]  byte_en = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   logic [31:0] m_h, m_v;
   logic        m_flag;
   logic [2:0]  m_wait;
   logic [7:0]  m_gpio;
   logic [15:0] m_tim;

   always #5 clk = ~clk;

   appreg_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                   .byte_en(byte_en), .wr_data(wr_data), .rd_data(rd_data));

   task automatic m_defaults();
      m_h = 32'h0000_07FF; m_v = 32'h0000_07FF;
      m_wait = 3'd0; m_gpio = 8'hFF; m_tim = 16'h0;
   endtask

   function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] d, logic [3:0] be);
      logic [31:0] r = o;
      for (int l = 0; l < 4; l++) if (be[l]) r[l*8 +: 8] = d[l*8 +: 8];
      return r;
   endfunction

   task automatic m_write(logic [11:0] a, logic [3:0] be, logic [31:0] d);
      case (a[11:2])
         10'd0:  m_h = merge(m_h, d, be);
         10'd1:  m_v = merge(m_v, d, be);
         10'd10: begin
            if (be[3]) begin
               m_flag = d[24];
               if (!d[24]) begin m_defaults(); return; end
            end
            if (be[2]) m_wait = d[18:16];
            if (be[0]) m_gpio = d[7:0];
         end
         10'd11: begin
            if (be[1]) m_tim[15:8] = d[15:8];
            if (be[0]) m_tim[7:0]  = d[7:0];
         end
         default: ;
      endcase
   endtask

   function automatic logic [31:0] m_read(logic [11:0] a);
      case (a[11:2])
         10'd0:  return m_h;
         10'd1:  return m_v;
         10'd10: return {7'd0, m_flag, 5'd0, m_wait, 8'd0, m_gpio};
         10'd11: return {8'h7E, 8'h00, m_tim};
         10'd17: return 32'h0000_0003;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s addr=%h got=%h exp=%h", req, addr, got, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [3:0] be, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; byte_en = be; wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0; byte_en = '0;
      m_write(a, be, d);
   endtask

   task automatic rd(string req, logic [11:0] a);
      @(negedge clk);
      wr_en = 1'b0; addr = a;
      #1;
      chk(req, rd_data, m_read(a));
   endtask

   task automatic rd_mapped(string req);
      rd(req, 12'h000); rd(req, 12'h004); rd(req, 12'h028);
      rd(req, 12'h02C); rd(req, 12'h044);
   endtask

   initial begin
      m_flag = 1'b0;
      m_defaults();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R2: reset values, with fixed expectations
      @(negedge clk); addr = 12'h000; #1; chk("R2 hcfg", rd_data, 32'h0000_07FF);
      @(negedge clk); addr = 12'h004; #1; chk("R2 vcfg", rd_data, 32'h0000_07FF);
      @(negedge clk); addr = 12'h028; #1; chk("R2 ctrl", rd_data, 32'h0000_00FF);
      @(negedge clk); addr = 12'h02C; #1; chk("R2 guest", rd_data, 32'h7E00_0000);
      @(negedge clk); addr = 12'h044; #1; chk("R8 stat", rd_data, 32'h0000_0003);

      // R1 / R9: whole window read, every byte address of the mapped words
      for (int w = 0; w < 1024; w++) rd("R9 sweep", 12'(w * 4));
      for (int b = 0; b < 4; b++) begin
         rd("R1 low bits", 12'h000 + 12'(b)); rd("R1 low bits", 12'h028 + 12'(b));
         rd("R7 low bits", 12'h02C + 12'(b)); rd("R8 low bits", 12'h044 + 12'(b));
      end

      // R3: all lane patterns on both config words
      for (int be = 0; be < 16; be++) begin
         wr(12'h000, 4'(be), 32'hA5C3_9E10 ^ (32'(be) * 32'h0101_0101));
         rd("R3 hcfg", 12'h000); rd("R3 vcfg untouched", 12'h004);
         wr(12'h006, 4'(be), 32'h3C5A_F00F + 32'(be));
         rd("R3 vcfg", 12'h004); rd("R3 hcfg untouched", 12'h000);
      end

      // R5: control lanes with flag kept at 1 on lane 3
      for (int be = 0; be < 16; be++) begin
         wr(12'h028, 4'(be), 32'h01F8_0000 | (32'(be) << 16) | 32'(8'h5A ^ 8'(be * 17)));
         rd("R5 ctrl", 12'h028);
      end

      // R6 / R7: guest-bus lanes including ignored upper lanes
      for (int be = 0; be < 16; be++) begin
         wr(12'h02C, 4'(be), 32'hFFFF_0000 | (32'(be) * 32'h0000_1357));
         rd("R6 guest", 12'h02C);
      end

      // R8 / R9: writes to status and unmapped offsets change nothing
      wr(12'h044, 4'hF, 32'hFFFF_FFFF);
      wr(12'h008, 4'hF, 32'h1234_5678);
      wr(12'hFFC, 4'hF, 32'hDEAD_BEEF);
      wr(12'h030, 4'hF, 32'h0000_0000);
      rd_mapped("R9 after unmapped writes");
      rd("R9 unmapped", 12'h008); rd("R9 unmapped", 12'hFFC);

      // R4: soft reset with other lanes enabled drops them
      wr(12'h000, 4'hF, 32'h1111_2222); wr(12'h004, 4'hF, 32'h3333_4444);
      wr(12'h02C, 4'h3, 32'h0000_ABCD); wr(12'h028, 4'h5, 32'h0005_0033);
      wr(12'h028, 4'hD, 32'h0007_0055);
      rd_mapped("R4 soft reset");
      @(negedge clk); addr = 12'h028; #1; chk("R4 ctrl default", rd_data, 32'h0000_00FF);
      // flag set to 1 keeps other lanes working
      wr(12'h028, 4'hD, 32'h0106_0011);
      @(negedge clk); addr = 12'h028; #1; chk("R4 flag set", rd_data, 32'h0106_0011);
      wr(12'h004, 4'h2, 32'h0000_5500);
      rd("R4 write after flag", 12'h004);
      // soft reset by lane 3 alone
      wr(12'h028, 4'h8, 32'h0000_0000);
      rd_mapped("R4 lane3 only");
      @(negedge clk); addr = 12'h02C; #1; chk("R4 guest default", rd_data, 32'h7E00_0000);

      // hardware reset mid-run
      wr(12'h000, 4'hF, 32'hFFFF_FFFF); wr(12'h028, 4'hF, 32'h0107_00AA);
      @(negedge clk) rst_n = 1'b0;
      m_flag = 1'b0; m_defaults();
      @(negedge clk) rst_n = 1'b1;
      rd_mapped("R2 after hw reset");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired got=0 exp=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule